// File: doc/BRIEF.md
# I2C Target Front End with Deferred Disable

This block is the bus-facing half of an I2C target (slave) port. It watches the already synchronized SCL and SDA lines, finds START and STOP conditions, shifts in the 7-bit address MSB first, compares it with a programmed own address, and recognises the all-zero general call address. It acknowledges by asserting an SDA pull-down enable (`sda_oe`) during the ninth clock. On write transfers it delivers each acknowledged byte with a one-cycle valid pulse. On read transfers it shifts out `tx_byte` until the master answers with a NACK.

Software may clear `enable` at any time. The block does not drop off the bus mid-byte. It lets the transfer in flight run on, answers every later address or data byte with a forced NACK, and only then reports itself disabled on `status[0]`. Two sticky flags record why the disable was disruptive. `status[1]` is set when a target operation was cut short. `status[2]` is set when a write had already entered its data phase. Both flags are cleared when the block is enabled again.

The controller is a single state machine:
- States: `ST_IDLE`, `ST_ADDR`, `ST_ADDR_ACK`, `ST_RX`, `ST_RX_ACK`, `ST_TX`, `ST_TX_ACK`, `ST_IGNORE`.
- Transitions:
  - A START moves any state to `ST_ADDR`, provided the block is enabled and `enable` is high; otherwise the START moves it to `ST_IDLE`. A STOP moves any state to `ST_IDLE`.
  - `ST_ADDR` goes to `ST_ADDR_ACK` on the falling SCL edge after eight bits.
  - `ST_ADDR_ACK` goes to `ST_TX` (acknowledged read), `ST_RX` (acknowledged write) or `ST_IGNORE` (NACK) on the next falling edge.
  - `ST_RX` goes to `ST_RX_ACK` after eight bits. `ST_RX_ACK` goes back to `ST_RX` if the byte was acknowledged, else to `ST_IGNORE`.
  - `ST_TX` goes to `ST_TX_ACK` after eight bits. `ST_TX_ACK` goes back to `ST_TX` on a master ACK, else to `ST_IGNORE`.

Top module: `i2c_tgt_core`

## Requirements
- R1: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. A START seen in the middle of a transfer (repeated START) restarts address reception from the first bit.
- R2: The address byte is sampled MSB first on rising SCL edges. Bits 7..1 are the address and bit 0 is the direction (1 = read). A matching address is acknowledged by asserting `sda_oe` through the ninth clock. A non-matching address is not acknowledged, and the rest of that transfer is ignored.
- R3: The general call (address 0, write) is acknowledged and raises a one-cycle `gc_hit` pulse only when `gc_ack_en` is 1. With `gc_ack_en` at 0 it gets no ACK and no pulse.
- R4: In a write transfer, each data byte is acknowledged while `enable` is high. That byte appears on `rx_byte` with a one-cycle `rx_valid` pulse. A byte that is NACKed gives no pulse.
- R5: In a read transfer, `tx_byte` is loaded at the start of each byte and driven MSB first (`sda_oe` = 1 drives a 0). The transfer continues while the master ACKs. It ends on a master NACK, after which `sda_oe` stays released.
- R6: `status[0]` shows the actual enabled state. It rises one cycle after `enable` is set. After `enable` is cleared, it stays 1 until no target transfer is in flight, then falls. While it is 0, every transfer is ignored and never acknowledged.
- R7: Clearing `enable` while an address byte is being received forces a NACK on that address, whether it matches or not and whatever its direction. It also sets sticky `status[1]`.
- R8: Clearing `enable` during a data byte of an acknowledged write forces a NACK on that byte with no `rx_valid`. It sets `status[1]` and `status[2]`.
- R9: If `enable` is already cleared and the master ends an acknowledged write's data phase with a STOP before any NACK is given, `status[1]` and `status[2]` are still both set.
- R10: Clearing `enable` while the bus is idle, or while a transfer for another address is running, sets neither `status[1]` nor `status[2]`.
- R11: `status[1]` and `status[2]` stay set until `status[0]` goes from 0 to 1 on re-enable, which clears both.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronized SCL level |
| sda_i | input | 1 | Synchronized SDA level |
| enable | input | 1 | Software enable request |
| gc_ack_en | input | 1 | Acknowledge the general call when 1 |
| own_addr | input | 7 | Programmed target address |
| tx_byte | input | 8 | Byte to send in read transfers |
| sda_oe | output | 1 | SDA pull-down enable (1 = drive low) |
| rx_byte | output | 8 | Last acknowledged received byte |
| rx_valid | output | 1 | One-cycle pulse when `rx_byte` is new |
| gc_hit | output | 1 | One-cycle pulse on an acknowledged general call |
| status | output | 3 | {data lost, disabled while busy, actually enabled} |

## Verification
The bench drives the bus with an open-drain model, so the target's ACKs and read data come back on the SDA level it samples. The tests cover writes to the own address, to a foreign address and to the general call with both settings of `gc_ack_en`. This separates address matching from general-call gating. Reads with a master ACK and then a NACK show byte reloading and the end of a transfer, and a repeated START shows the address restart. The disable tests clear `enable` in the idle bus, in a foreign transfer, in a read address, in a write address and in a write data byte, plus once just before a STOP. Each case has its own expected pair of sticky flags, so the bench can tell the in-flight abort, the lost-data case and the harmless cases apart.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

    localparam int ADDR_W = 7;
    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_RX,
        ST_RX_ACK,
        ST_TX,
        ST_TX_ACK,
        ST_IGNORE
    } tgt_state_t;

endpackage

// File: rtl/i2c_tgt_cond.sv
module i2c_tgt_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic start_det,
    output logic stop_det,
    output logic scl_rise,
    output logic scl_fall
);

    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    always_comb begin
        start_det = scl_i && scl_q && sda_q && !sda_i;
        stop_det  = scl_i && scl_q && !sda_q && sda_i;
        scl_rise  = scl_i && !scl_q;
        scl_fall  = !scl_i && scl_q;
    end

endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm
    import i2c_tgt_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int BW = BYTE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_det,
    input  logic          stop_det,
    input  logic          scl_rise,
    input  logic          scl_fall,
    input  logic          sda_in,
    input  logic          en_req,
    input  logic          en_act,
    input  logic          gc_ack_en,
    input  logic [AW-1:0] own_addr,
    input  logic [BW-1:0] tx_byte,
    output logic          sda_oe,
    output logic [BW-1:0] rx_byte,
    output logic          rx_valid,
    output logic          gc_hit,
    output logic          busy,
    output logic          abort_busy,
    output logic          abort_lost
);

    localparam int CNT_W = $clog2(BW + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(BW);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BW - 1);
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    tgt_state_t       state;
    tgt_state_t       state_nx;
    logic [CNT_W-1:0] cnt;
    logic [BW-1:0]    shreg;
    logic [BW-1:0]    txsh;
    logic             ack_q;
    logic             rw_q;
    logic             m_ack;

    logic [AW-1:0]    addr_fld;
    logic             rw_bit;
    logic             is_match;
    logic             is_gc;
    logic             addr_ok;
    logic             byte_end;
    logic             in_write;
    logic             in_data;

    always_comb begin
        addr_fld = shreg[BW-1:1];
        rw_bit   = shreg[0];
        is_match = (addr_fld == own_addr);
        is_gc    = (addr_fld == '0) && !rw_bit;
        addr_ok  = en_req && (is_match || (is_gc && gc_ack_en));
        byte_end = scl_fall && (cnt == FULL);
        in_data  = (state == ST_RX) || (state == ST_RX_ACK);
        in_write = (state == ST_ADDR) || in_data ||
                   ((state == ST_ADDR_ACK) && !rw_q);
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        if (start_det) begin
            state_nx = (en_act && en_req) ? ST_ADDR : ST_IDLE;
        end else if (stop_det) begin
            state_nx = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:     state_nx = ST_IDLE;
                ST_ADDR:     if (byte_end) state_nx = ST_ADDR_ACK;
                ST_ADDR_ACK: if (scl_fall)
                                 state_nx = !ack_q ? ST_IGNORE : (rw_q ? ST_TX : ST_RX);
                ST_RX:       if (byte_end) state_nx = ST_RX_ACK;
                ST_RX_ACK:   if (scl_fall) state_nx = ack_q ? ST_RX : ST_IGNORE;
                ST_TX:       if (scl_fall && cnt == LAST) state_nx = ST_TX_ACK;
                ST_TX_ACK:   if (scl_fall) state_nx = m_ack ? ST_TX : ST_IGNORE;
                ST_IGNORE:   state_nx = ST_IGNORE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt        <= '0;
            shreg      <= '0;
            txsh       <= '0;
            ack_q      <= 1'b0;
            rw_q       <= 1'b0;
            m_ack      <= 1'b0;
            rx_byte    <= '0;
            rx_valid   <= 1'b0;
            gc_hit     <= 1'b0;
            abort_busy <= 1'b0;
            abort_lost <= 1'b0;
        end else begin
            rx_valid   <= 1'b0;
            gc_hit     <= 1'b0;
            abort_busy <= 1'b0;
            abort_lost <= 1'b0;
            if (start_det || stop_det) begin
                cnt   <= '0;
                ack_q <= 1'b0;
                if (!en_req && in_write) abort_busy <= 1'b1;
                if (!en_req && in_data)  abort_lost <= 1'b1;
            end else begin
                unique case (state)
                    ST_ADDR: begin
                        if (scl_rise) begin
                            shreg <= {shreg[BW-2:0], sda_in};
                            cnt   <= cnt + ONE;
                        end
                        if (byte_end) begin
                            ack_q      <= addr_ok;
                            rw_q       <= rw_bit;
                            gc_hit     <= addr_ok && is_gc;
                            abort_busy <= !en_req;
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (scl_fall) begin
                            cnt  <= '0;
                            txsh <= tx_byte;
                        end
                    end
                    ST_RX: begin
                        if (scl_rise) begin
                            shreg <= {shreg[BW-2:0], sda_in};
                            cnt   <= cnt + ONE;
                        end
                        if (byte_end) begin
                            ack_q      <= en_req;
                            rx_valid   <= en_req;
                            rx_byte    <= shreg;
                            abort_busy <= !en_req;
                            abort_lost <= !en_req;
                        end
                    end
                    ST_RX_ACK: begin
                        if (scl_fall) cnt <= '0;
                    end
                    ST_TX: begin
                        if (scl_fall) begin
                            txsh <= {txsh[BW-2:0], 1'b1};
                            cnt  <= cnt + ONE;
                        end
                    end
                    ST_TX_ACK: begin
                        if (scl_rise) m_ack <= !sda_in;
                        if (scl_fall) begin
                            txsh <= tx_byte;
                            cnt  <= '0;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        sda_oe = 1'b0;
        busy   = 1'b1;
        unique case (state)
            ST_IDLE:     busy = 1'b0;
            ST_IGNORE:   busy = 1'b0;
            ST_ADDR_ACK: sda_oe = ack_q;
            ST_RX_ACK:   sda_oe = ack_q;
            ST_TX:       sda_oe = !txsh[BW-1];
            default:     sda_oe = 1'b0;
        endcase
    end

    // R4
    rx_valid_acked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> (sda_oe && state == ST_RX_ACK));

    // R7
    addr_forced_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADDR_ACK && $past(state) == ST_ADDR && !$past(en_req)) |-> !sda_oe);

    // R3
    gc_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gc_hit |-> $past(gc_ack_en));

    // R2
    quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sda_oe);

endmodule

// File: rtl/i2c_tgt_enctl.sv
module i2c_tgt_enctl (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic busy,
    input  logic abort_busy,
    input  logic abort_lost,
    output logic en_act,
    output logic flag_busy,
    output logic flag_lost
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_act    <= 1'b0;
            flag_busy <= 1'b0;
            flag_lost <= 1'b0;
        end else begin
            if (enable && !en_act) begin
                en_act    <= 1'b1;
                flag_busy <= 1'b0;
                flag_lost <= 1'b0;
            end else if (!enable && en_act && !busy) begin
                en_act <= 1'b0;
            end
            if (abort_busy) flag_busy <= 1'b1;
            if (abort_lost) flag_lost <= 1'b1;
        end
    end

    // R6
    late_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(en_act) |-> !$past(busy));

    // R11
    flags_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en_act) |-> (!flag_busy && !flag_lost));

    // R8
    lost_implies_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_lost |-> flag_busy);

endmodule

// File: rtl/i2c_tgt_core.sv
module i2c_tgt_core
    import i2c_tgt_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int BW = BYTE_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          scl_i,
    input  logic          sda_i,
    input  logic          enable,
    input  logic          gc_ack_en,
    input  logic [AW-1:0] own_addr,
    input  logic [BW-1:0] tx_byte,
    output logic          sda_oe,
    output logic [BW-1:0] rx_byte,
    output logic          rx_valid,
    output logic          gc_hit,
    output logic [2:0]    status
);

    logic start_det;
    logic stop_det;
    logic scl_rise;
    logic scl_fall;
    logic busy;
    logic abort_busy;
    logic abort_lost;
    logic en_act;
    logic flag_busy;
    logic flag_lost;

    i2c_tgt_cond u_cond (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .start_det (start_det),
        .stop_det  (stop_det),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall)
    );

    i2c_tgt_fsm #(.AW(AW), .BW(BW)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_det  (start_det),
        .stop_det   (stop_det),
        .scl_rise   (scl_rise),
        .scl_fall   (scl_fall),
        .sda_in     (sda_i),
        .en_req     (enable),
        .en_act     (en_act),
        .gc_ack_en  (gc_ack_en),
        .own_addr   (own_addr),
        .tx_byte    (tx_byte),
        .sda_oe     (sda_oe),
        .rx_byte    (rx_byte),
        .rx_valid   (rx_valid),
        .gc_hit     (gc_hit),
        .busy       (busy),
        .abort_busy (abort_busy),
        .abort_lost (abort_lost)
    );

    i2c_tgt_enctl u_enctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .busy       (busy),
        .abort_busy (abort_busy),
        .abort_lost (abort_lost),
        .en_act     (en_act),
        .flag_busy  (flag_busy),
        .flag_lost  (flag_lost)
    );

    assign status = {flag_lost, flag_busy, en_act};

    // R6
    disabled_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !status[0] |-> !sda_oe);

endmodule

// File: tb/test_i2c_tgt_core.sv
module test_i2c_tgt_core;

    localparam int Q = 4;
    localparam logic [6:0] OWN = 7'h2A;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       enable = 1'b0;
    logic       gc_ack_en = 1'b0;
    logic [7:0] tx_byte = 8'h00;
    logic       sda_oe;
    logic [7:0] rx_byte;
    logic       rx_valid;
    logic       gc_hit;
    logic [2:0] status;
    logic       sda_bus;

    int n_tests = 0;
    int n_fail  = 0;
    int rx_cnt  = 0;
    int gc_cnt  = 0;
    logic [7:0] rx_last = 8'h00;

    always #2 clk = ~clk;

    assign sda_bus = sda_m & ~sda_oe;

    i2c_tgt_core i_i2c_tgt_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_m),
        .sda_i     (sda_bus),
        .enable    (enable),
        .gc_ack_en (gc_ack_en),
        .own_addr  (OWN),
        .tx_byte   (tx_byte),
        .sda_oe    (sda_oe),
        .rx_byte   (rx_byte),
        .rx_valid  (rx_valid),
        .gc_hit    (gc_hit),
        .status    (status)
    );

    always @(negedge clk) begin
        if (rx_valid) begin
            rx_cnt  = rx_cnt + 1;
            rx_last = rx_byte;
        end
        if (gc_hit) gc_cnt = gc_cnt + 1;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start;
        sda_m = 1'b1; wait_cyc(Q);
        scl_m = 1'b1; wait_cyc(Q);
        sda_m = 1'b0; wait_cyc(Q);
        scl_m = 1'b0; wait_cyc(Q);
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; wait_cyc(Q);
        scl_m = 1'b1; wait_cyc(Q);
        sda_m = 1'b1; wait_cyc(Q);
    endtask

    task automatic put_bit(input logic b);
        sda_m = b;    wait_cyc(Q);
        scl_m = 1'b1; wait_cyc(Q);
        scl_m = 1'b0; wait_cyc(Q);
    endtask

    task automatic get_bit(output logic b);
        sda_m = 1'b1; wait_cyc(Q);
        scl_m = 1'b1; wait_cyc(2);
        b = sda_bus;  wait_cyc(2);
        scl_m = 1'b0; wait_cyc(Q);
    endtask

    // sends a byte; enable is cleared before bit index 'cut' (7 = MSB) when cut >= 0
    task automatic send_byte(input logic [7:0] d, input int cut, output logic ack);
        logic x;
        for (int i = 7; i >= 0; i--) begin
            if (i == cut) enable = 1'b0;
            put_bit(d[i]);
        end
        get_bit(x);
        ack = !x;
    endtask

    task automatic recv_byte(output logic [7:0] d, input logic mack, input logic [7:0] nxt);
        logic x;
        for (int i = 7; i >= 0; i--) begin
            get_bit(x);
            d[i] = x;
        end
        tx_byte = nxt;
        put_bit(!mack);
    endtask

    task automatic reenable;
        enable = 1'b1;
        wait_cyc(3);
        check("R11 flags cleared on re-enable", status, 3'b001);
    endtask

    task automatic t_reset;
        check("R6 reset status", status, 3'b000);
        check("R6 reset sda_oe", sda_oe, 1'b0);
        enable = 1'b1;
        wait_cyc(1);
        check("R6 status[0] rises one cycle after enable", status, 3'b001);
    endtask

    task automatic t_write;
        logic ack;
        int c0 = rx_cnt;
        bus_start;
        send_byte({OWN, 1'b0}, -1, ack);
        check("R2 own address acked", ack, 1'b1);
        send_byte(8'hA5, -1, ack);
        check("R4 data byte acked", ack, 1'b1);
        check("R4 first byte value", rx_last, 8'hA5);
        send_byte(8'h5A, -1, ack);
        bus_stop;
        check("R4 rx_valid count", rx_cnt - c0, 2);
        check("R4 second byte value", rx_last, 8'h5A);
    endtask

    task automatic t_miss;
        logic ack;
        int c0 = rx_cnt;
        bus_start;
        send_byte({7'h15, 1'b0}, -1, ack);
        check("R2 foreign address nacked", ack, 1'b0);
        send_byte(8'h00, -1, ack);
        check("R2 foreign data ignored", ack, 1'b0);
        bus_stop;
        check("R2 no rx_valid for foreign", rx_cnt - c0, 0);
    endtask

    task automatic t_gc;
        logic ack;
        int g0 = gc_cnt;
        gc_ack_en = 1'b0;
        bus_start;
        send_byte(8'h00, -1, ack);
        check("R3 general call nacked when disabled", ack, 1'b0);
        check("R3 no gc_hit when disabled", gc_cnt - g0, 0);
        bus_stop;
        gc_ack_en = 1'b1;
        bus_start;
        send_byte(8'h00, -1, ack);
        check("R3 general call acked", ack, 1'b1);
        check("R3 gc_hit pulse", gc_cnt - g0, 1);
        send_byte(8'h11, -1, ack);
        check("R3 general call data", rx_last, 8'h11);
        bus_stop;
        gc_ack_en = 1'b0;
    endtask

    task automatic t_read;
        logic ack;
        logic [7:0] b;
        tx_byte = 8'h3C;
        bus_start;
        send_byte({OWN, 1'b1}, -1, ack);
        check("R5 read address acked", ack, 1'b1);
        recv_byte(b, 1'b1, 8'hC3);
        check("R5 first read byte", b, 8'h3C);
        recv_byte(b, 1'b0, 8'h00);
        check("R5 second read byte", b, 8'hC3);
        wait_cyc(2);
        check("R5 sda released after master NACK", sda_oe, 1'b0);
        bus_stop;
        check("R5 still enabled", status, 3'b001);
    endtask

    task automatic t_restart;
        logic ack;
        bus_start;
        put_bit(1'b1); put_bit(1'b0); put_bit(1'b1); put_bit(1'b1);
        bus_start;
        send_byte({OWN, 1'b0}, -1, ack);
        check("R1 address after repeated START acked", ack, 1'b1);
        send_byte(8'h77, -1, ack);
        bus_stop;
        check("R1 data after repeated START", rx_last, 8'h77);
    endtask

    task automatic t_dis_addr;
        logic ack;
        bus_start;
        send_byte({OWN, 1'b0}, 4, ack);
        check("R7 write address forced NACK", ack, 1'b0);
        bus_stop;
        wait_cyc(2);
        check("R7 status after address abort", status, 3'b010);
        reenable;
    endtask

    task automatic t_dis_data;
        logic ack;
        int c0;
        bus_start;
        send_byte({OWN, 1'b0}, -1, ack);
        c0 = rx_cnt;
        put_bit(1'b1); put_bit(1'b0); put_bit(1'b0); put_bit(1'b1);
        enable = 1'b0;
        wait_cyc(3);
        check("R6 status[0] held while transfer in flight", status[0], 1'b1);
        put_bit(1'b0); put_bit(1'b1); put_bit(1'b1); put_bit(1'b0);
        get_bit(ack);
        check("R8 data byte forced NACK", ack, 1'b1);
        check("R8 no rx_valid on forced NACK", rx_cnt - c0, 0);
        wait_cyc(2);
        check("R8 status after data abort", status, 3'b110);
        bus_stop;
        reenable;
    endtask

    task automatic t_dis_stop;
        logic ack;
        bus_start;
        send_byte({OWN, 1'b0}, -1, ack);
        put_bit(1'b0); put_bit(1'b1); put_bit(1'b1);
        enable = 1'b0;
        wait_cyc(2);
        bus_stop;
        wait_cyc(2);
        check("R9 STOP before NACK sets both flags", status, 3'b110);
        reenable;
    endtask

    task automatic t_dis_idle;
        enable = 1'b0;
        wait_cyc(3);
        check("R10 idle disable sets no flag", status, 3'b000);
        reenable;
    endtask

    task automatic t_dis_other;
        logic ack;
        bus_start;
        send_byte({7'h15, 1'b0}, -1, ack);
        put_bit(1'b1); put_bit(1'b0);
        enable = 1'b0;
        wait_cyc(3);
        check("R10 foreign transfer disable sets no flag", status, 3'b000);
        put_bit(1'b1); put_bit(1'b0); put_bit(1'b1); put_bit(1'b0);
        put_bit(1'b1); put_bit(1'b0);
        get_bit(ack);
        bus_stop;
        check("R10 still no flag after foreign transfer", status, 3'b000);
        reenable;
    endtask

    task automatic t_dis_read_addr;
        logic ack;
        bus_start;
        send_byte({OWN, 1'b1}, 2, ack);
        check("R7 read address forced NACK", ack, 1'b0);
        bus_stop;
        wait_cyc(2);
        check("R7 status after read address abort", status, 3'b010);
        reenable;
    endtask

    task automatic t_disabled_ignore;
        logic ack;
        enable = 1'b0;
        wait_cyc(3);
        bus_start;
        send_byte({OWN, 1'b0}, -1, ack);
        check("R6 disabled target ignores own address", ack, 1'b0);
        bus_stop;
        check("R6 disabled status", status, 3'b000);
        reenable;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(2);
        t_reset;
        t_write;
        t_miss;
        t_gc;
        t_read;
        t_restart;
        t_dis_addr;
        t_dis_data;
        t_dis_stop;
        t_dis_idle;
        t_dis_other;
        t_dis_read_addr;
        t_disabled_ignore;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule